// File: doc/BRIEF.md
# Lane Coordinate Handshake Buffer

This block gathers lane coordinates from an upstream detector into a fixed 40-entry store and passes that store to software through a start/done handshake. A fill begins only on command from the hardware side. Each valid coordinate is written at the next slot. When the last slot is written, a ready flag tells software that the full set can be read.

Software then raises its own start line. While it works, the store is frozen and any coordinates that arrive are dropped. When software lowers its start line, the ready flag clears and the block waits for the next fill command. The hardware side can also cancel a fill part-way with its done line. The store is read through an index port that returns one entry at a time, with no delay.

Top module: `coord_handshake_buf`

## Requirements
- R1: After reset the ready flag is low and every slot of the store reads as zero.
- R2: When idle, a fill starts only in a cycle where both the enable input and the hardware start input are high. Coordinates offered while idle are not stored.
- R3: During a fill, each cycle with the valid flag high stores the coordinate at the next slot, counting up from slot 0. Cycles with the valid flag low store nothing and do not advance the slot.
- R4: The ready flag rises in the cycle after the 40th coordinate of a fill is stored, and never before that.
- R5: While the ready flag is high, incoming coordinates are dropped and all 40 slots keep their values.
- R6: With the ready flag high, software ownership begins only on a low-to-high change of the software start input. If that input is already high when the fill completes, lowering it does not release the buffer.
- R7: Once software owns the buffer, a low level on the software start input clears the ready flag in the next cycle and returns the block to idle. The next fill writes again from slot 0.
- R8: A high hardware done input during a fill cancels it: the block returns to idle and the ready flag stays low. A coordinate offered in the same cycle is not stored, and the next fill restarts at slot 0.
- R9: The read data output shows the slot selected by the 6-bit read index in the same cycle. An index of 40 or more reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; qualifies the fill start |
| hw_start_i | input | 1 | Hardware request to begin a fill |
| hw_done_i | input | 1 | Hardware cancel of a fill in progress |
| sw_start_i | input | 1 | Software start; high while software uses the buffer |
| coord_i | input | 10 | Lane coordinate |
| coord_vld_i | input | 1 | Coordinate valid flag |
| rd_idx_i | input | 6 | Read slot index |
| rd_data_o | output | 10 | Coordinate stored at the read slot |
| data_ready_o | output | 1 | Full buffer available to software |

## Verification
Fills are run in two forms: back-to-back valid cycles, and valid cycles mixed with idle ones. Comparing the two shows whether the slot counter advances on valid data only. Coordinates are also offered while idle, while frozen, with only one of the two start qualifiers high, and in the same cycle as a cancel. These cases show whether writes are gated by state or merely by the valid flag. A cancelled fill followed by a full one with a different pattern shows whether slot 0 is rewritten. Raising the software start input before the fill completes, and comparing that with raising it afterwards, separates edge detection from level detection.

// File: rtl/coord_hs_pkg.sv
`timescale 1ns/1ps
package coord_hs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_READY = 2'd2,
        ST_HOLD  = 2'd3
    } hs_state_e;
endpackage

// File: rtl/coord_hs_ctrl.sv
`timescale 1ns/1ps
module coord_hs_ctrl
    import coord_hs_pkg::*;
#(
    parameter int DEPTH = 40,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             hw_start_i,
    input  logic             hw_done_i,
    input  logic             sw_start_i,
    input  logic             coord_vld_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic             data_ready_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        hs_state_e        state;
        logic [IDX_W-1:0] idx;
        logic             sw_prev;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        r_d.sw_prev = sw_start_i;
        wr_en_o     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (en_i && hw_start_i) begin
                    r_d.state = ST_FILL;
                    r_d.idx   = '0;
                end
            end
            ST_FILL: begin
                if (hw_done_i) begin
                    r_d.state = ST_IDLE;
                    r_d.idx   = '0;
                end else if (coord_vld_i) begin
                    wr_en_o = 1'b1;
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == LAST) begin
                        r_d.state = ST_READY;
                    end
                end
            end
            ST_READY: begin
                if (sw_start_i && !r_q.sw_prev) begin
                    r_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!sw_start_i) begin
                    r_d.state = ST_IDLE;
                    r_d.idx   = '0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, idx: '0, sw_prev: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_idx_o     = r_q.idx;
    assign data_ready_o = (r_q.state == ST_READY) || (r_q.state == ST_HOLD);

    p_idle_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !(en_i && hw_start_i)) |=> (r_q.state == ST_IDLE));

    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_idx_o <= LAST));

    p_ready_after_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready_o) |-> $past(wr_en_o && (wr_idx_o == LAST)));

    p_no_write_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o |-> !wr_en_o);

    p_release_on_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD && !sw_start_i) |=> !data_ready_o);

    p_cancel_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FILL && hw_done_i) |=> (r_q.state == ST_IDLE && !data_ready_o));
endmodule

// File: rtl/coord_hs_store.sv
`timescale 1ns/1ps
module coord_hs_store #(
    parameter int DEPTH   = 40,
    parameter int COORD_W = 10,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [COORD_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [COORD_W-1:0] rd_data_o
);
    logic [DEPTH-1:0][COORD_W-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
                mem_d[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_data_o = mem_q[i];
            end
        end
    end

    p_frozen_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mem_q));

    p_out_of_range_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_i >= IDX_W'(DEPTH)) |-> (rd_data_o == '0));
endmodule

// File: rtl/coord_handshake_buf.sv
`timescale 1ns/1ps
module coord_handshake_buf #(
    parameter int   DEPTH   = 40,
    parameter int   COORD_W = 10,
    localparam int  IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               hw_start_i,
    input  logic               hw_done_i,
    input  logic               sw_start_i,
    input  logic [COORD_W-1:0] coord_i,
    input  logic               coord_vld_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [COORD_W-1:0] rd_data_o,
    output logic               data_ready_o
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    coord_hs_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .hw_start_i   (hw_start_i),
        .hw_done_i    (hw_done_i),
        .sw_start_i   (sw_start_i),
        .coord_vld_i  (coord_vld_i),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .data_ready_o (data_ready_o)
    );

    coord_hs_store #(.DEPTH(DEPTH), .COORD_W(COORD_W), .IDX_W(IDX_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (coord_i),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/coord_handshake_buf_tb_top.sv
`timescale 1ns/1ps
module coord_handshake_buf_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, hw_start = 1'b0, hw_done = 1'b0, sw_start = 1'b0;
    logic [9:0] coord = '0;
    logic       vld = 1'b0;
    logic [5:0] rd_idx = '0;
    logic [9:0] rd_data;
    logic       data_ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit scan = 1'b0;

    always #2 clk = ~clk;

    coord_handshake_buf dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .hw_start_i(hw_start),
        .hw_done_i(hw_done), .sw_start_i(sw_start), .coord_i(coord),
        .coord_vld_i(vld), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
        .data_ready_o(data_ready)
    );

    // behavioural reference: 0 idle, 1 filling, 2 full waiting, 3 software owns
    int m_st = 0;
    int m_cnt = 0;
    bit m_swp = 1'b0;
    int m_mem [40];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_swp <= 1'b0;
            for (int i = 0; i < 40; i++) m_mem[i] <= 0;
        end else begin
            m_swp <= sw_start;
            if (m_st == 0) begin
                if (en && hw_start) begin m_st <= 1; m_cnt <= 0; end
            end else if (m_st == 1) begin
                if (hw_done) begin m_st <= 0; m_cnt <= 0; end
                else if (vld) begin
                    m_mem[m_cnt] <= int'(coord);
                    m_cnt <= m_cnt + 1;
                    if (m_cnt == 39) m_st <= 2;
                end
            end else if (m_st == 2) begin
                if (sw_start && !m_swp) m_st <= 3;
            end else begin
                if (!sw_start) m_st <= 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // comparison against the model on every clock, just after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R4 ready flag vs model", int'(data_ready), (m_st >= 2) ? 1 : 0);
            chk("R9 read data vs model", int'(rd_data), (rd_idx < 40) ? m_mem[rd_idx] : 0);
        end
    end

    always @(negedge clk) if (scan) rd_idx <= rd_idx + 6'd1;

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic start_fill();
        @(negedge clk); en = 1'b1; hw_start = 1'b1;
        @(negedge clk); hw_start = 1'b0;
    endtask

    task automatic feed(input int n, input int base, input bit gaps);
        for (int k = 0; k < n; k++) begin
            if (gaps && (k % 3 == 0)) begin
                @(negedge clk); vld = 1'b0; coord = 10'h3FF;
            end
            @(negedge clk); vld = 1'b1; coord = 10'((base + k * 37) & 10'h3FF);
        end
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic read_at(input int idx, input string req, input int exp);
        @(negedge clk); rd_idx = 6'(idx);
        #1 chk(req, int'(rd_data), exp);
    endtask

    initial begin
        tick(3);
        #1 chk("R1 ready low in reset exit", int'(data_ready), 0);
        @(negedge clk); rst_n = 1'b1;
        settle();
        chk("R1 ready low after reset", int'(data_ready), 0);
        read_at(0, "R1 slot 0 zero after reset", 0);
        read_at(39, "R1 slot 39 zero after reset", 0);

        // R2: only one qualifier high, coordinates offered while idle
        @(negedge clk); en = 1'b0; hw_start = 1'b1; vld = 1'b1; coord = 10'd77;
        @(negedge clk); en = 1'b1; hw_start = 1'b0; coord = 10'd88;
        @(negedge clk); vld = 1'b0; en = 1'b0;
        tick(2);
        read_at(0, "R2 idle coordinates not stored", 0);
        chk("R2 no fill without both qualifiers", int'(data_ready), 0);

        // R3/R4: fill with gaps
        start_fill();
        feed(39, 100, 1'b1);
        settle();
        chk("R4 ready low after 39 coordinates", int'(data_ready), 0);
        @(negedge clk); vld = 1'b1; coord = 10'd555;
        @(negedge clk); vld = 1'b0;
        #1 chk("R4 ready high after 40th", int'(data_ready), 1);
        read_at(0, "R3 slot 0 first coordinate", 100);
        read_at(5, "R3 slot 5 skips gap cycles", (100 + 5 * 37) & 1023);
        read_at(39, "R3 slot 39 last coordinate", 555);

        // R5: coordinates dropped while full
        @(negedge clk); vld = 1'b1; coord = 10'd999;
        tick(3); vld = 1'b0;
        read_at(0, "R5 slot 0 unchanged while ready", 100);
        read_at(39, "R5 slot 39 unchanged while ready", 555);

        // R7: software takes and releases
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); vld = 1'b1; coord = 10'd321;
        tick(2); vld = 1'b0;
        read_at(1, "R5 slot 1 unchanged while owned", 137);
        chk("R7 ready held while software owns", int'(data_ready), 1);
        @(negedge clk); sw_start = 1'b0;
        settle();
        chk("R7 ready clears after release", int'(data_ready), 0);

        // R8: cancel with simultaneous valid
        start_fill();
        feed(10, 200, 1'b0);
        @(negedge clk); hw_done = 1'b1; vld = 1'b1; coord = 10'd44;
        @(negedge clk); hw_done = 1'b0; vld = 1'b0;
        read_at(10, "R8 cancel-cycle coordinate not stored", (100 + 10 * 37) & 1023);
        tick(3);
        chk("R8 ready stays low after cancel", int'(data_ready), 0);

        // R6 and R7 restart at slot 0: software start high before fill completes
        start_fill();
        @(negedge clk); sw_start = 1'b1;
        feed(40, 600, 1'b0);
        tick(2);
        chk("R6 ready high after full fill", int'(data_ready), 1);
        read_at(0, "R7 new fill restarts at slot 0", 600);
        @(negedge clk); sw_start = 1'b0;
        tick(3);
        chk("R6 level without rise does not release", int'(data_ready), 1);
        @(negedge clk); sw_start = 1'b1;
        tick(2);
        @(negedge clk); sw_start = 1'b0;
        settle();
        chk("R6 release after proper rise", int'(data_ready), 0);

        // R9: sweep of all index values including out-of-range ones
        read_at(40, "R9 index 40 reads zero", 0);
        read_at(63, "R9 index 63 reads zero", 0);
        @(negedge clk); scan = 1'b1;
        tick(70);
        scan = 1'b0;
        tick(2);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule